// File: doc/BRIEF.md
# Pipelined ADC Front-Stage Calibration Sequencer

This block runs foreground calibration for the four front stages of a pipelined ADC. These are one 1.5-bit stage, two 2.5-bit stages and one 3.5-bit stage. The later 1.5-bit stages are not calibrated.

A calibration run starts with a start pulse while the mode input selects offset or slope calibration. The block visits the calibrated stages one at a time, beginning with the least significant. For each stage it walks through the code-transition segments. For each point it raises a stimulus request, naming the stage and the segment, and waits for a valid-qualified captured code.

- In offset mode, every segment gets its own coefficient. The coefficient is the captured code minus a computed ideal code, minus the coefficient already found for the matching segment of the previously calibrated stage.
- In slope mode, only the first and last segment of each stage are measured. The block stores one gain-error term per stage.

When the run ends, a done flag is raised. A debug mode reads the coefficient store, the gain terms and the last captured code back through the output ports. An abort input stops a run at once.

Top module: `adc_stage_cal_top`

## Requirements
- R1: After reset, calBusy, calDone and stimReq are 0. Every coefficient and gain entry reads back as 0 through the debug port.
- R2: A calStart pulse while idle begins a run when modeSel is 1 (offset) or 2 (slope). A calStart pulse while modeSel is 0 (normal) or 3 (debug) leaves calBusy at 0.
- R3: An offset run visits the points in this order:
  - Stages go in order 0, 1, 2, 3. Stage 0 is the 1.5-bit stage, stages 1 and 2 are the 2.5-bit stages, and stage 3 is the 3.5-bit stage.
  - Within a stage, segments go in ascending order. The segment count is SEG_BASE shifted left by the stage level. The levels are 0, 1, 1 and 2, which gives 6, 12, 12 and 24 points.
  - stimReq is high while a point waits for capValid. stimStage and stimSeg name that point.
  - stimReq drops for one cycle between points.
- R4: The offset coefficient of stage s, segment j is D - (j+1)*(REF_SPAN >> level(s)) - P, truncated to COEF_W bits in two's complement. D is the captured code.
  - P is 0 for stage 0.
  - For a later stage, P is the stored coefficient of stage s-1 at segment j, or at j - count(s-1) when j is at least count(s-1).
- R5: A slope run requests only segment 0 and the last segment of each stage, in stage order 0 to 3. The stage gain term is (Dlast - Dfirst) - (count-1)*(REF_SPAN >> level). A slope run leaves every offset coefficient unchanged.
- R6: When the last point of stage 3 is captured, calDone is 1 and calBusy is 0 from the next cycle on. calDone stays 1 until the next accepted start.
- R7: A calStart pulse during a run is ignored. The pending point, stimStage and stimSeg do not change.
- R8: calAbort during a run makes calBusy 0 on the next cycle and leaves calDone at 0. A point captured in the abort cycle is not written. Entries not yet visited keep their earlier values.
- R9: With modeSel at 3 and the block idle, the debug outputs show values one cycle after the address is applied:
  - dbgCoef shows the entry at {dbgStage, dbgSeg}. A segment of 4*SEG_BASE or more reads 0.
  - dbgGain shows the gain term of dbgStage.
  - dbgCapture shows the last captured code.
  - In any other mode, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | 0 normal, 1 offset calibration, 2 slope calibration, 3 debug |
| calStart | input | 1 | Start pulse for a calibration run |
| calAbort | input | 1 | Stops a run and returns to idle |
| capValid | input | 1 | Captured stage code is valid |
| capData | input | DATA_W | Captured stage output code |
| stimReq | output | 1 | Request for the test stimulus on the named stage |
| stimStage | output | 2 | Stage being calibrated |
| stimSeg | output | 5 | Segment being measured |
| calBusy | output | 1 | Run in progress |
| calDone | output | 1 | Last run completed |
| dbgStage | input | 2 | Debug read stage |
| dbgSeg | input | 5 | Debug read segment |
| dbgCoef | output | COEF_W | Debug coefficient read data |
| dbgGain | output | COEF_W | Debug gain term of dbgStage |
| dbgCapture | output | DATA_W | Debug copy of the last captured code |

## Verification
The assertions rely on one assumption about the capture side: capValid is raised only while stimReq is high, for a single cycle per point. They also assume that a start pulse arriving while a run is active comes without a capture in the same cycle.

The bench keeps to this in three ways:
- It raises capValid only after it sees stimReq at a falling edge, and lowers it one cycle later.
- It issues the stray start pulse while a point is still pending.
- It applies abort only together with a pending capture.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  localparam int STAGE_N = 4;
  localparam int STAGE_W = 2;
  localparam int SEG_W   = 5;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_OFFSET = 2'd1,
    MODE_SLOPE  = 2'd2,
    MODE_DEBUG  = 2'd3
  } calMode_e;

  typedef struct packed {
    logic               wrOffset;
    logic               keepFirst;
    logic               wrGain;
    logic [STAGE_W-1:0] stage;
    logic [SEG_W-1:0]   seg;
  } calStrobe_t;

  // Resolution level: 1.5-bit -> 0, 2.5-bit -> 1, 3.5-bit -> 2
  function automatic int stageLevel(int s);
    if (s == 0) return 0;
    if (s == STAGE_N - 1) return 2;
    return 1;
  endfunction

  function automatic int segCount(int segBase, int s);
    return segBase << stageLevel(s);
  endfunction
endpackage

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int SEG_BASE = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic               calStart,
  input  logic               calAbort,
  input  logic               capValid,
  output logic               stimReq,
  output logic [STAGE_W-1:0] stimStage,
  output logic [SEG_W-1:0]   stimSeg,
  output logic               calBusy,
  output logic               calDone,
  output logic               debugView,
  output calStrobe_t         strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_STIM, ST_GAP} ctrlState_e;

  ctrlState_e         stateQ;
  logic [STAGE_W-1:0] stageQ;
  logic [SEG_W-1:0]   segQ;
  logic               slopeRunQ;
  logic               doneQ;
  logic [SEG_W-1:0]   lastSeg;
  logic               endOfStage;
  logic               capEdge;
  calMode_e           modeNow;

  assign modeNow = calMode_e'(modeSel);

  always_comb begin
    lastSeg    = SEG_W'(segCount(SEG_BASE, int'(stageQ)) - 1);
    endOfStage = slopeRunQ ? (segQ != '0) : (segQ == lastSeg);
    capEdge    = (stateQ == ST_STIM) && capValid && !calAbort;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      stageQ    <= '0;
      segQ      <= '0;
      slopeRunQ <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (calStart && (modeNow == MODE_OFFSET || modeNow == MODE_SLOPE)) begin
            stateQ    <= ST_STIM;
            stageQ    <= '0;
            segQ      <= '0;
            doneQ     <= 1'b0;
            slopeRunQ <= (modeNow == MODE_SLOPE);
          end
        end
        ST_STIM: begin
          if (calAbort) begin
            stateQ <= ST_IDLE;
          end else if (capValid) begin
            if (endOfStage) begin
              if (stageQ == STAGE_W'(STAGE_N - 1)) begin
                stateQ <= ST_IDLE;
                doneQ  <= 1'b1;
              end else begin
                stageQ <= stageQ + 1'b1;
                segQ   <= '0;
                stateQ <= ST_GAP;
              end
            end else begin
              segQ   <= slopeRunQ ? lastSeg : segQ + 1'b1;
              stateQ <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          stateQ <= calAbort ? ST_IDLE : ST_STIM;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.wrOffset  = capEdge && !slopeRunQ;
    strobe.keepFirst = capEdge && slopeRunQ && (segQ == '0);
    strobe.wrGain    = capEdge && slopeRunQ && (segQ != '0);
    strobe.stage     = stageQ;
    strobe.seg       = segQ;
  end

  assign stimReq   = (stateQ == ST_STIM);
  assign stimStage = stageQ;
  assign stimSeg   = segQ;
  assign calBusy   = (stateQ != ST_IDLE);
  assign calDone   = doneQ;
  assign debugView = (stateQ == ST_IDLE) && (modeNow == MODE_DEBUG);

  // R3: stages are visited in rising order within a run
  assert_stage_order_R3: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && $past(calBusy)) |-> (stimStage >= $past(stimStage)));

  // R3: requested segment always lies inside the stage's segment range
  assert_seg_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    stimReq |-> (int'(stimSeg) < segCount(SEG_BASE, int'(stimStage))));

  // R7: a start pulse during a pending point changes nothing
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stimReq && calStart && !capValid && !calAbort) |=> (stimReq && $stable(stimStage) && $stable(stimSeg)));

  // R8: abort ends the run on the next cycle without done
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (calBusy && calAbort) |=> (!calBusy && !calDone));

  // R6: done only appears with the controller idle
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> !calBusy);
endmodule

// File: rtl/adc_cal_datapath.sv
module adc_cal_datapath
  import adc_cal_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int COEF_W   = 12,
  parameter int SEG_BASE = 6,
  parameter int REF_SPAN = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  calStrobe_t               strobe,
  input  logic [DATA_W-1:0]        capData,
  input  logic                     debugView,
  input  logic [STAGE_W-1:0]       dbgStage,
  input  logic [SEG_W-1:0]         dbgSeg,
  output logic signed [COEF_W-1:0] dbgCoef,
  output logic signed [COEF_W-1:0] dbgGain,
  output logic [DATA_W-1:0]        dbgCapture
);
  localparam int MAX_SEG = SEG_BASE << 2;

  logic signed [COEF_W-1:0] coefArr [STAGE_N][MAX_SEG];
  logic signed [COEF_W-1:0] gainArr [STAGE_N];
  logic [DATA_W-1:0]        firstCap;
  logic [DATA_W-1:0]        lastCap;

  logic [STAGE_W-1:0]       prevStage;
  logic [SEG_W-1:0]         priorIdx;
  logic signed [COEF_W-1:0] priorCoef;
  logic signed [COEF_W-1:0] newCoef;
  logic signed [COEF_W-1:0] newGain;
  int                       stepNow;
  int                       cntNow;
  int                       prevCnt;
  int                       offsetVal;
  int                       gainVal;

  // Ideal code and previous-stage term for the point being captured
  always_comb begin
    stepNow   = REF_SPAN >> stageLevel(int'(strobe.stage));
    cntNow    = segCount(SEG_BASE, int'(strobe.stage));
    prevStage = strobe.stage - 1'b1;
    prevCnt   = (strobe.stage == '0) ? cntNow : segCount(SEG_BASE, int'(prevStage));
    priorIdx  = (int'(strobe.seg) >= prevCnt) ? SEG_W'(int'(strobe.seg) - prevCnt) : strobe.seg;
    priorCoef = (strobe.stage == '0) ? '0 : coefArr[prevStage][priorIdx];
    offsetVal = int'(capData) - (int'(strobe.seg) + 1) * stepNow - int'(priorCoef);
    gainVal   = int'(capData) - int'(firstCap) - (cntNow - 1) * stepNow;
    newCoef   = COEF_W'(offsetVal);
    newGain   = COEF_W'(gainVal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGE_N; s++) begin
        gainArr[s] <= '0;
        for (int j = 0; j < MAX_SEG; j++) coefArr[s][j] <= '0;
      end
      firstCap <= '0;
      lastCap  <= '0;
    end else begin
      if (strobe.wrOffset && int'(strobe.seg) < MAX_SEG)
        coefArr[strobe.stage][strobe.seg] <= newCoef;
      if (strobe.wrGain)
        gainArr[strobe.stage] <= newGain;
      if (strobe.keepFirst)
        firstCap <= capData;
      if (strobe.wrOffset || strobe.wrGain || strobe.keepFirst)
        lastCap <= capData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgCoef    <= '0;
      dbgGain    <= '0;
      dbgCapture <= '0;
    end else begin
      dbgCoef    <= (debugView && int'(dbgSeg) < MAX_SEG) ? coefArr[dbgStage][dbgSeg] : '0;
      dbgGain    <= debugView ? gainArr[dbgStage] : '0;
      dbgCapture <= debugView ? lastCap : '0;
    end
  end

  // R4: at most one write strobe per cycle from the controller
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrOffset, strobe.keepFirst, strobe.wrGain}));

  // R5: a gain write targets the last segment of its stage
  assert_gain_on_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrGain |-> (int'(strobe.seg) == cntNow - 1));

  // R5: the first slope point is always segment zero
  assert_first_is_seg0_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.keepFirst |-> (strobe.seg == '0));
endmodule

// File: rtl/adc_stage_cal_top.sv
module adc_stage_cal_top
  import adc_cal_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int COEF_W   = 12,
  parameter int SEG_BASE = 6,
  parameter int REF_SPAN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              calStart,
  input  logic              calAbort,
  input  logic              capValid,
  input  logic [DATA_W-1:0] capData,
  output logic              stimReq,
  output logic [1:0]        stimStage,
  output logic [4:0]        stimSeg,
  output logic              calBusy,
  output logic              calDone,
  input  logic [1:0]        dbgStage,
  input  logic [4:0]        dbgSeg,
  output logic [COEF_W-1:0] dbgCoef,
  output logic [COEF_W-1:0] dbgGain,
  output logic [DATA_W-1:0] dbgCapture
);
  calStrobe_t strobe;
  logic       debugView;

  adc_cal_ctrl #(.SEG_BASE(SEG_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .calStart(calStart),
    .calAbort(calAbort), .capValid(capValid), .stimReq(stimReq),
    .stimStage(stimStage), .stimSeg(stimSeg), .calBusy(calBusy),
    .calDone(calDone), .debugView(debugView), .strobe(strobe)
  );

  adc_cal_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .SEG_BASE(SEG_BASE), .REF_SPAN(REF_SPAN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .capData(capData),
    .debugView(debugView), .dbgStage(dbgStage), .dbgSeg(dbgSeg),
    .dbgCoef(dbgCoef), .dbgGain(dbgGain), .dbgCapture(dbgCapture)
  );
endmodule

// File: tb/tb_adc_stage_cal_top.sv
module tb_adc_stage_cal_top;
  localparam int DATA_W = 12;
  localparam int COEF_W = 12;
  localparam int SEG_BASE = 6;
  localparam int REF_SPAN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic calStart = 1'b0, calAbort = 1'b0, capValid = 1'b0;
  logic [DATA_W-1:0] capData = '0;
  logic stimReq, calBusy, calDone;
  logic [1:0] stimStage;
  logic [4:0] stimSeg;
  logic [1:0] dbgStage = '0;
  logic [4:0] dbgSeg = '0;
  logic [COEF_W-1:0] dbgCoef, dbgGain;
  logic [DATA_W-1:0] dbgCapture;

  int tests = 0, fails = 0;
  int expCoef [4][24];
  int expGain [4];
  int lastD = 0;

  always #4 clk = ~clk;

  adc_stage_cal_top dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .calStart(calStart),
    .calAbort(calAbort), .capValid(capValid), .capData(capData),
    .stimReq(stimReq), .stimStage(stimStage), .stimSeg(stimSeg),
    .calBusy(calBusy), .calDone(calDone), .dbgStage(dbgStage),
    .dbgSeg(dbgSeg), .dbgCoef(dbgCoef), .dbgGain(dbgGain),
    .dbgCapture(dbgCapture)
  );

  function automatic int lvlOf(int s);
    return (s == 0) ? 0 : (s == 3) ? 2 : 1;
  endfunction
  function automatic int cntOf(int s);
    return SEG_BASE << lvlOf(s);
  endfunction
  function automatic int stepOf(int s);
    return REF_SPAN >> lvlOf(s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic startRun(input logic [1:0] m);
    @(negedge clk);
    modeSel = m; calStart = 1'b1;
    @(negedge clk);
    calStart = 1'b0;
  endtask

  task automatic waitReq();
    while (!stimReq) @(negedge clk);
  endtask

  task automatic capture(input int d, input bit abortNow);
    capData = DATA_W'(d); capValid = 1'b1; calAbort = abortNow;
    @(negedge clk);
    capValid = 1'b0; calAbort = 1'b0;
  endtask

  task automatic readBack(input int s, input int j, output int coef, output int gain);
    @(negedge clk);
    modeSel = 2'd3; dbgStage = 2'(s); dbgSeg = 5'(j);
    @(negedge clk);
    coef = int'($signed(dbgCoef));
    gain = int'($signed(dbgGain));
  endtask

  // Offset run; stopAt >= 0 aborts while capturing that point index
  task automatic offsetRun(input int salt, input int stopAt, input bit poke);
    int idx = 0;
    startRun(2'd1);
    for (int s = 0; s < 4; s++) begin
      for (int j = 0; j < cntOf(s); j++) begin
        int err, prior, pj, d;
        waitReq();
        check(stimStage == 2'(s) && stimSeg == 5'(j), "R3 order",
              int'(stimStage) * 100 + int'(stimSeg), s * 100 + j);
        if (poke && s == 1 && j == 2) begin
          calStart = 1'b1;
          @(negedge clk);
          calStart = 1'b0;
          check(stimReq && stimStage == 2'd1 && stimSeg == 5'd2, "R7 start ignored",
                int'(stimStage) * 100 + int'(stimSeg), 102);
        end
        err = ((s * 5 + j * 3 + salt) % 9) - 4;
        if (s == 0) prior = 0;
        else begin
          pj = (j >= cntOf(s - 1)) ? j - cntOf(s - 1) : j;
          prior = expCoef[s - 1][pj];
        end
        d = (j + 1) * stepOf(s) + prior + err;
        if (idx == stopAt) begin
          capture(d, 1'b1);
          return;
        end
        capture(d, 1'b0);
        expCoef[s][j] = err;
        lastD = d;
        idx++;
        if (!(s == 3 && j == cntOf(3) - 1))
          check(!stimReq, "R3 gap between points", int'(stimReq), 0);
      end
    end
  endtask

  initial begin
    int c, g;
    for (int s = 0; s < 4; s++) begin
      expGain[s] = 0;
      for (int j = 0; j < 24; j++) expCoef[s][j] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!calBusy && !calDone && !stimReq, "R1 reset flags",
          int'(calBusy) + int'(calDone) + int'(stimReq), 0);
    readBack(3, 23, c, g);
    check(c == 0 && g == 0, "R1 reset coefficients", c + g, 0);

    // R2: start ignored in normal and debug modes
    startRun(2'd0);
    check(!calBusy, "R2 normal start", int'(calBusy), 0);
    startRun(2'd3);
    check(!calBusy, "R2 debug start", int'(calBusy), 0);

    // R2/R3/R4/R7: full offset run
    startRun(2'd0);
    offsetRun(0, -1, 1'b1);
    @(negedge clk);
    check(calDone && !calBusy, "R6 done after stage 3", int'(calDone) * 10 + int'(calBusy), 10);
    for (int s = 0; s < 4; s++)
      for (int j = 0; j < 24; j++) begin
        readBack(s, j, c, g);
        check(c == expCoef[s][j], "R4 offset coefficient", c, expCoef[s][j]);
      end
    check(calDone, "R6 done held", int'(calDone), 1);
    check(int'(dbgCapture) == lastD, "R9 last capture", int'(dbgCapture), lastD);
    readBack(0, 30, c, g);
    check(c == 0, "R9 out-of-range segment", c, 0);
    @(negedge clk);
    modeSel = 2'd0; dbgStage = 2'd0; dbgSeg = 5'd0;
    @(negedge clk);
    check(dbgCoef == '0 && dbgCapture == '0, "R9 zero outside debug",
          int'(dbgCoef) + int'(dbgCapture), 0);

    // R5: slope run
    startRun(2'd2);
    check(calBusy && !calDone, "R6 done cleared on start", int'(calDone), 0);
    for (int s = 0; s < 4; s++) begin
      int last, a, b, d0, dl;
      last = cntOf(s) - 1;
      a = s + 1; b = 3 - 2 * s;
      waitReq();
      check(stimStage == 2'(s) && stimSeg == 5'd0, "R5 first point",
            int'(stimStage) * 100 + int'(stimSeg), s * 100);
      d0 = stepOf(s) + a;
      capture(d0, 1'b0);
      waitReq();
      check(stimStage == 2'(s) && int'(stimSeg) == last, "R5 last point",
            int'(stimStage) * 100 + int'(stimSeg), s * 100 + last);
      dl = (last + 1) * stepOf(s) + b;
      capture(dl, 1'b0);
      expGain[s] = b - a;
    end
    @(negedge clk);
    check(calDone && !calBusy, "R6 slope done", int'(calDone), 1);
    for (int s = 0; s < 4; s++) begin
      readBack(s, 0, c, g);
      check(g == expGain[s], "R5 gain term", g, expGain[s]);
      check(c == expCoef[s][0], "R5 offsets untouched", c, expCoef[s][0]);
    end
    readBack(3, 23, c, g);
    check(c == expCoef[3][23], "R5 offsets untouched", c, expCoef[3][23]);

    // R8: abort on the fourth point of a new offset run
    offsetRun(4, 3, 1'b0);
    check(!calBusy && !calDone, "R8 abort idle", int'(calBusy) * 10 + int'(calDone), 0);
    for (int j = 0; j < 6; j++) begin
      readBack(0, j, c, g);
      check(c == expCoef[0][j], "R8 stage 0 after abort", c, expCoef[0][j]);
    end
    for (int j = 0; j < 12; j++) begin
      readBack(1, j, c, g);
      check(c == expCoef[1][j], "R8 stage 1 kept", c, expCoef[1][j]);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule